// File: doc/BRIEF.md
# Sticky Reset Cause Status Register

This block keeps a record of which reset sources have fired since the chip last powered up. Five independent sources each own one sticky status bit: a software watchdog expiry, a core checkstop (recorded only while checkstop reset is enabled), a debug-port hard reset request, a debug-port soft reset request and a JTAG reset request. Each source delivers a single-cycle pulse. Once a bit is set it stays set until software clears it or power-on reset arrives. Every other reset, including the system reset input of this block, leaves the record intact. Boot software can therefore learn why the chip restarted.

Software reaches the register over a simple word-wide register bus with a select, a write enable, an address and write data. A write clears each status bit whose data bit is 1 and leaves bits written with 0 untouched. A read returns the current register word one cycle later, together with a one-cycle valid pulse. A read never changes the register. The bus is plain control with no back-pressure: the block accepts every access in the cycle it is presented.

Top module: `rcs_status_reg`

## Requirements
- R1: Power-on reset (`por_n` low) forces all five status bits to 0. The first read after its release returns 0x0000_0000.
- R2: A one-cycle pulse on a source sets that source's bit at the next rising edge. The bit then stays 1. Bit positions in the read word: bit 3 watchdog, bit 4 checkstop, bit 5 debug hard, bit 6 debug soft, bit 7 JTAG.
- R3: A write to the register address clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: A `core_chkstop` pulse sets bit 4 only when `chkstop_rst_en` is 1 in the same cycle. With the enable at 0, the pulse leaves bit 4 unchanged.
- R5: Read-word bits 0 to 2 and 8 to 31 always read 0, and writing 1 to them has no visible effect.
- R6: When a source pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R7: Holding `sys_rst_n` low leaves every status bit unchanged. While it is low, `rd_valid` and `rd_data` stay 0.
- R8: A read (`bus_sel`=1, `bus_we`=0, address equal to `REG_ADDR`) produces `rd_valid`=1 one cycle later. `rd_data` then holds the register value from the request cycle. Back-to-back reads return identical words when no event or write intervenes.
- R9: Accesses whose address differs from `REG_ADDR` neither clear any bit nor produce `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; the only reset of the status bits |
| sys_rst_n | input | 1 | System reset, synchronous, active low; clears only the read port |
| wdog_expire | input | 1 | Software watchdog expiry pulse |
| core_chkstop | input | 1 | Core checkstop entry pulse |
| chkstop_rst_en | input | 1 | Checkstop reset enable level |
| dbg_hard_req | input | 1 | Debug-port hard reset request pulse |
| dbg_soft_req | input | 1 | Debug-port soft reset request pulse |
| jtag_rst_req | input | 1 | JTAG reset request pulse |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data (1 bits clear) |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | DATA_W | Read data word |

## Verification
A status bit changes at the first rising edge after its pulse or clear. A read therefore sees the effect only if it is issued one or more cycles after the stimulus. Read data and `rd_valid` appear at the rising edge that ends the request cycle. The bench drives every input at the falling edge and computes the expected word from its own model before that edge. It samples both read outputs 2 ns after the rising edge, so every comparison lands exactly one cycle after its request. The bench also checks that cycles without an accepted read show `rd_valid` low. This holds for sys-reset cycles, for cycles that hit another address and for cycles with no access at all.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned SRC_LSB = 3;

  typedef enum int unsigned {
    SRC_WDOG     = 0,
    SRC_CHKSTOP  = 1,
    SRC_DBG_HARD = 2,
    SRC_DBG_SOFT = 3,
    SRC_JTAG     = 4
  } src_idx_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rcs_bus_decode.sv
module rcs_bus_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic                  rd_hit,
  output rcs_pkg::src_vec_t     clr_mask
);
  import rcs_pkg::*;

  logic addr_match;
  logic wr_hit;
  logic unused_wdata;

  assign addr_match = (bus_addr == REG_ADDR);
  assign wr_hit     = bus_sel & bus_we & addr_match;
  assign rd_hit     = bus_sel & ~bus_we & addr_match;

  always_comb begin
    clr_mask = '0;
    if (wr_hit) clr_mask = bus_wdata[SRC_LSB +: NUM_SRC];
  end

  // reserved data bits carry no meaning for a write
  assign unused_wdata = ^{bus_wdata[DATA_W-1:SRC_LSB+NUM_SRC], bus_wdata[SRC_LSB-1:0]};
endmodule

// File: rtl/rcs_sticky_bit.sv
module rcs_sticky_bit (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // only power-on reset touches the cell; a set beats a same-cycle clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rcs_read_port.sv
module rcs_read_port #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] word_i,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (!sys_rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      rd_data  <= rd_hit ? word_i : '0;
    end
  end
endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wdog_expire,
  input  logic              core_chkstop,
  input  logic              chkstop_rst_en,
  input  logic              dbg_hard_req,
  input  logic              dbg_soft_req,
  input  logic              jtag_rst_req,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import rcs_pkg::*;

  src_vec_t          set_vec;
  src_vec_t          clr_mask;
  src_vec_t          status_q;
  logic              rd_hit;
  logic [DATA_W-1:0] word;

  always_comb begin
    set_vec               = '0;
    set_vec[SRC_WDOG]     = wdog_expire;
    set_vec[SRC_CHKSTOP]  = core_chkstop & chkstop_rst_en;
    set_vec[SRC_DBG_HARD] = dbg_hard_req;
    set_vec[SRC_DBG_SOFT] = dbg_soft_req;
    set_vec[SRC_JTAG]     = jtag_rst_req;
  end

  rcs_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
  ) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_hit(rd_hit), .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    rcs_sticky_bit u_bit (
      .clk(clk), .por_n(por_n),
      .set_i(set_vec[i]), .clr_i(clr_mask[i]), .q_o(status_q[i])
    );
  end

  always_comb begin
    word = '0;
    word[SRC_LSB +: NUM_SRC] = status_q;
  end

  rcs_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .rd_hit(rd_hit),
    .word_i(word), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              wdog_expire,
  input logic              core_chkstop,
  input logic              chkstop_rst_en,
  input logic              dbg_hard_req,
  input logic              dbg_soft_req,
  input logic              jtag_rst_req,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input rcs_pkg::src_vec_t status_q
);
  import rcs_pkg::*;

  src_vec_t src_ev;
  src_vec_t wr_clr;
  logic     acc_rd;

  assign src_ev = {jtag_rst_req, dbg_soft_req, dbg_hard_req,
                   core_chkstop & chkstop_rst_en, wdog_expire};
  assign wr_clr = (bus_sel && bus_we && bus_addr == REG_ADDR)
                  ? bus_wdata[SRC_LSB +: NUM_SRC] : '0;
  assign acc_rd = bus_sel && !bus_we && bus_addr == REG_ADDR;

  // R1: status is zero whenever power-on reset is held
  always @(posedge clk) begin
    if (!por_n) assert_por_clear_R1: assert (status_q == '0);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prop
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!por_n)
      src_ev[i] |=> status_q[i]);
    assert_keep_unless_cleared_R3: assert property (@(posedge clk) disable iff (!por_n)
      (status_q[i] && !wr_clr[i]) |=> status_q[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!por_n)
      (wr_clr[i] && !src_ev[i]) |=> !status_q[i]);
    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!por_n)
      (!status_q[i] && !src_ev[i]) |=> !status_q[i]);
  end

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data[DATA_W-1:SRC_LSB+NUM_SRC] == '0) && (rd_data[SRC_LSB-1:0] == '0));

  assert_sysrst_quiet_R7: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> !rd_valid);

  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!por_n)
    (acc_rd && sys_rst_n) |=> rd_valid);

  assert_no_stray_valid_R9: assert property (@(posedge clk) disable iff (!por_n)
    !acc_rd |=> !rd_valid);
endmodule

bind rcs_status_reg rcs_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
  .wdog_expire(wdog_expire), .core_chkstop(core_chkstop),
  .chkstop_rst_en(chkstop_rst_en), .dbg_hard_req(dbg_hard_req),
  .dbg_soft_req(dbg_soft_req), .jtag_rst_req(jtag_rst_req),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
  .status_q(status_q)
);

// File: tb/test_rcs_status_reg.sv
module test_rcs_status_reg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0] RA = 8'h14;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1;
  logic wdog_expire = 0, core_chkstop = 0, chkstop_rst_en = 0;
  logic dbg_hard_req = 0, dbg_soft_req = 0, jtag_rst_req = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;

  int total = 0, failed = 0;
  bit done = 0;
  logic [4:0] model = '0;   // bit0 watchdog .. bit4 JTAG

  always #5 clk = ~clk;

  rcs_status_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(RA)) i_rcs_status_reg (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .wdog_expire(wdog_expire), .core_chkstop(core_chkstop),
    .chkstop_rst_en(chkstop_rst_en), .dbg_hard_req(dbg_hard_req),
    .dbg_soft_req(dbg_soft_req), .jtag_rst_req(jtag_rst_req),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [31:0] word_of(input logic [4:0] m);
    logic [31:0] w;
    w = '0;
    w[7:3] = m;
    return w;
  endfunction

  function automatic logic [4:0] next_of(input logic [4:0] cur, input logic [4:0] ev,
      input logic en, input logic wr, input logic [31:0] wd);
    logic [4:0] s, c;
    s = ev;
    s[1] = ev[1] & en;
    c = wr ? wd[7:3] : 5'b0;
    return (cur & ~c) | s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs applied at falling edge, outputs sampled 2 ns after rising edge
  task automatic cyc(input string tag, input logic [4:0] ev, input logic en,
      input logic sel, input logic we, input logic [7:0] addr,
      input logic [31:0] wd, input logic srst_n);
    logic hit, ev_v;
    logic [31:0] ev_d;
    {jtag_rst_req, dbg_soft_req, dbg_hard_req, core_chkstop, wdog_expire} = ev;
    chkstop_rst_en = en; bus_sel = sel; bus_we = we; bus_addr = addr;
    bus_wdata = wd; sys_rst_n = srst_n;
    hit  = sel && (addr == RA);
    ev_v = hit && !we && srst_n;
    ev_d = ev_v ? word_of(model) : 32'h0;
    model = next_of(model, ev, en, hit && we, wd);
    @(posedge clk); #2;
    check({tag, " rd_valid"}, {31'b0, rd_valid}, {31'b0, ev_v});
    check({tag, " rd_data"}, rd_data, ev_d);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 5'b0, 1'b0, 1'b0, 1'b0, 8'h0, 32'h0, 1'b1);
  endtask

  task automatic rd(input string tag);
    cyc(tag, 5'b0, 1'b0, 1'b1, 1'b0, RA, 32'h0, 1'b1);
  endtask

  task automatic wr(input string tag, input logic [31:0] wd);
    cyc(tag, 5'b0, 1'b0, 1'b1, 1'b1, RA, wd, 1'b1);
  endtask

  task automatic do_por(input string tag);
    por_n = 1'b0;
    model = '0;
    @(posedge clk); #2;
    check({tag, " valid in por"}, {31'b0, rd_valid}, 32'h0);
    @(negedge clk);
    por_n = 1'b1;
    rd(tag); rd(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    do_por("R1");

    // R2: each source alone, then read the word
    for (int i = 0; i < 5; i++) begin
      cyc("R2", 5'b1 << i, 1'b1, 1'b0, 1'b0, 8'h0, 32'h0, 1'b1);
      idle("R2"); rd("R2");
    end
    check("R2 all set", {27'b0, model}, 32'h1f);

    // R3: write 0 keeps, write 1 clears
    wr("R3 write0", 32'h0); rd("R3 write0");
    wr("R3 clr bit4", 32'h10); rd("R3 clr bit4");
    wr("R3 clr all", 32'hf8); rd("R3 clr all");

    // R4: checkstop gated by enable
    cyc("R4 en0", 5'b00010, 1'b0, 1'b0, 1'b0, 8'h0, 32'h0, 1'b1); rd("R4 en0");
    check("R4 not recorded", {27'b0, model}, 32'h0);
    cyc("R4 en1", 5'b00010, 1'b1, 1'b0, 1'b0, 8'h0, 32'h0, 1'b1); rd("R4 en1");

    // R5: reserved bits ignore writes and read 0
    wr("R5", 32'hffff_ff07); rd("R5");
    wr("R5 clr", 32'hffff_ffff); rd("R5 clr");

    // R6: event beats a same-cycle clear
    cyc("R6 set", 5'b00001, 1'b0, 1'b0, 1'b0, 8'h0, 32'h0, 1'b1);
    cyc("R6 race", 5'b10001, 1'b0, 1'b1, 1'b1, RA, 32'h88, 1'b1); rd("R6");

    // R7: system reset leaves status alone
    cyc("R7 set", 5'b01100, 1'b0, 1'b0, 1'b0, 8'h0, 32'h0, 1'b1);
    for (int i = 0; i < 3; i++)
      cyc("R7 sysrst", 5'b0, 1'b0, 1'b1, 1'b0, RA, 32'h0, 1'b0);
    rd("R7");

    // R8: back-to-back reads, identical words
    rd("R8 first"); rd("R8 second"); idle("R8 idle");

    // R9: other addresses ignored
    cyc("R9 wr", 5'b0, 1'b0, 1'b1, 1'b1, RA ^ 8'h01, 32'hffff_ffff, 1'b1);
    cyc("R9 rd", 5'b0, 1'b0, 1'b1, 1'b0, RA ^ 8'h40, 32'h0, 1'b1); rd("R9");

    do_por("R1 mid-run");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] ev;
      logic sel, we, srst;
      logic [7:0] a;
      ev = '0;
      for (int b = 0; b < 5; b++) ev[b] = ($urandom_range(0, 19) == 0);
      sel  = ($urandom_range(0, 2) != 0);
      we   = ($urandom_range(0, 2) == 0);
      a    = ($urandom_range(0, 7) == 0) ? 8'($urandom) : RA;
      srst = ($urandom_range(0, 29) != 0);
      cyc("R2/R3/R4/R6/R8 random", ev, 1'($urandom), sel, we, a, $urandom, srst);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule